// File: doc/BRIEF.md
# Reflected CRC32 Accumulate Unit

This execution unit advances a 32-bit CRC accumulator by one data operand of 8, 16, 32 or 64 bits, in the way a processor CRC instruction does. It takes the full 32-bit instruction word, the accumulator value, the 64-bit data register value and a strap that says whether the CRC feature is present. It returns the new accumulator and a flag that marks the instruction as undefined.

The arithmetic is the bit-reflected form of CRC. The accumulator and the data are both bit-reversed. The reversed accumulator, followed by zeros, is XORed with the reversed data, followed by zeros. That value is reduced modulo the selected polynomial over GF(2), and the 32-bit remainder is reversed back. No initial or final inversion is applied inside the unit: software adds those when it frames a message.

The core is combinational: one conditional-XOR stage per data bit. A single output register holds the result and the flag, so they appear one clock after the inputs.

Top module: `crc32_acc_unit`

## Requirements
- R1: While `rst_n` is low, `result` and `undef` are both 0.
- R2: The operand width is 8 shifted left by the size field, insn[11:10]. The value 00 gives 8 bits, 01 gives 16, 10 gives 32 and 11 gives 64. Only the low width bits of `data_in` affect `result`.
- R3: With insn[12] = 0, `result` is the reflected CRC step with polynomial 0x04C11DB7. Starting from 0xFFFFFFFF, stepping through the ASCII string "123456789" (first byte in the lowest bits) and inverting the end value gives 0xCBF43926.
- R4: With insn[12] = 1, the polynomial is 0x1EDC6F41. The same framing of "123456789" gives 0xE3069283.
- R5: `undef` is 1 when insn[31] is 1 and the size field is not 11. It is also 1 when insn[31] is 0 and the size field is 11.
- R6: `undef` is 1 whenever `feat_en` is 0.
- R7: `undef` is 1 when insn[30:21] differs from 0011010110 or insn[15:13] differs from 010.
- R8: Whenever `undef` is 1, `result` is 0.
- R9: `result` and `undef` reflect the inputs present at the previous rising clock edge.
- R10: The register-number fields insn[20:16], insn[9:5] and insn[4:0] have no effect on `result` or `undef`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn | input | 32 | Instruction word |
| feat_en | input | 1 | Strap: CRC feature present |
| acc_in | input | 32 | Accumulator operand |
| data_in | input | 64 | Data register value |
| result | output | 32 | Updated accumulator, registered |
| undef | output | 1 | Undefined-instruction flag, registered |

## Verification
On every cycle, the assertions check the following:
- the result is zeroed under the undefined flag;
- the flag rises one cycle after a missing feature, a bad width/sf pairing or a broken fixed field;
- the number of active reduction stages matches the width that the decoder selected.

Only the bench scenarios can show that the CRC values are correct for both polynomials and for each width. The same holds for the known check strings, the indifference to upper data bits and register fields, and the reset state.

// File: rtl/crc_acc_pkg.sv
package crc_acc_pkg;
  localparam int unsigned ACC_W  = 32;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned SZ_W   = 2;
  localparam logic [ACC_W-1:0] POLY_STD = 32'h04C11DB7;
  localparam logic [ACC_W-1:0] POLY_CAS = 32'h1EDC6F41;
  localparam logic [9:0] OPC_HI = 10'b0011010110;
  localparam logic [2:0] OPC_MID = 3'b010;

  typedef struct packed {
    logic            sf;
    logic            cast;
    logic [SZ_W-1:0] sz;
    logic            opc_ok;
  } crc_dec_t;

  function automatic logic [ACC_W-1:0] reflect_acc(input logic [ACC_W-1:0] v);
    logic [ACC_W-1:0] r;
    for (int i = 0; i < ACC_W; i++) r[i] = v[ACC_W-1-i];
    return r;
  endfunction

  // one LSB-first step: fold a data bit into the reflected register
  function automatic logic [ACC_W-1:0] lsb_step(input logic [ACC_W-1:0] c,
                                                input logic d,
                                                input logic [ACC_W-1:0] rpoly);
    logic fb;
    fb = c[0] ^ d;
    return (c >> 1) ^ (fb ? rpoly : '0);
  endfunction

  function automatic int unsigned width_of(input logic [SZ_W-1:0] sz);
    return 8 << sz;
  endfunction
endpackage

// File: rtl/crc_insn_decode.sv
module crc_insn_decode
  import crc_acc_pkg::*;
(
  input  logic [31:0] insn,
  input  logic        feat_en,
  output crc_dec_t    dec,
  output logic        illegal
);
  logic width_bad;

  always_comb begin
    dec.sf     = insn[31];
    dec.cast   = insn[12];
    dec.sz     = insn[11:10];
    dec.opc_ok = (insn[30:21] == OPC_HI) && (insn[15:13] == OPC_MID);
    width_bad  = dec.sf ? (dec.sz != 2'b11) : (dec.sz == 2'b11);
    illegal    = !feat_en || !dec.opc_ok || width_bad;
  end
endmodule

// File: rtl/crc_poly_select.sv
module crc_poly_select
  import crc_acc_pkg::*;
(
  input  logic             cast,
  output logic [ACC_W-1:0] rpoly
);
  localparam logic [ACC_W-1:0] RSTD = reflect_acc(POLY_STD);
  localparam logic [ACC_W-1:0] RCAS = reflect_acc(POLY_CAS);
  assign rpoly = cast ? RCAS : RSTD;
endmodule

// File: rtl/crc_reduce.sv
module crc_reduce
  import crc_acc_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ACC_W
) (
  input  logic [AW-1:0]   acc,
  input  logic [DW-1:0]   data,
  input  logic [SZ_W-1:0] sz,
  input  logic [AW-1:0]   rpoly,
  output logic [DW-1:0]   step_en,
  output logic [AW-1:0]   crc
);
  localparam int unsigned CW = $clog2(DW) + 1;
  logic [CW-1:0] nbits;
  logic [AW-1:0] chain [DW+1];

  assign nbits = CW'(width_of(sz));
  assign chain[0] = acc;

  for (genvar i = 0; i < DW; i++) begin : g_stage
    assign step_en[i] = (CW'(i) < nbits);
    assign chain[i+1] = step_en[i] ? lsb_step(chain[i], data[i], rpoly) : chain[i];
  end

  assign crc = chain[DW];
endmodule

// File: rtl/crc32_acc_unit.sv
module crc32_acc_unit
  import crc_acc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] insn,
  input  logic        feat_en,
  input  logic [31:0] acc_in,
  input  logic [63:0] data_in,
  output logic [31:0] result,
  output logic        undef
);
  crc_dec_t          dec;
  logic              illegal;
  logic [ACC_W-1:0]  rpoly;
  logic [DATA_W-1:0] step_en;
  logic [ACC_W-1:0]  crc_c;

  crc_insn_decode u_dec (.insn(insn), .feat_en(feat_en), .dec(dec), .illegal(illegal));
  crc_poly_select u_poly (.cast(dec.cast), .rpoly(rpoly));
  crc_reduce #(.DW(DATA_W), .AW(ACC_W)) u_red (
    .acc(acc_in), .data(data_in), .sz(dec.sz), .rpoly(rpoly),
    .step_en(step_en), .crc(crc_c));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      undef  <= 1'b0;
    end else begin
      result <= illegal ? '0 : crc_c;
      undef  <= illegal;
    end
  end
endmodule

// File: rtl/crc32_acc_chk.sv
module crc32_acc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] insn,
  input logic        feat_en,
  input logic [31:0] result,
  input logic        undef,
  input logic [63:0] step_en
);
  // R8
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> (result == 32'h0));
  // R6
  no_feature_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !feat_en |=> undef);
  // R5
  bad_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn[31] != (insn[11:10] == 2'b11)) |=> undef);
  // R7
  bad_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((insn[30:21] != 10'b0011010110) || (insn[15:13] != 3'b010)) |=> undef);
  // R2
  stage_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(step_en) == (8 << insn[11:10]));
endmodule

bind crc32_acc_unit crc32_acc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .insn(insn), .feat_en(feat_en),
  .result(result), .undef(undef), .step_en(step_en));

// File: tb/sim_crc32_acc_unit.sv
module sim_crc32_acc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn = '0;
  logic        feat_en = 1'b1;
  logic [31:0] acc_in = '0;
  logic [63:0] data_in = '0;
  logic [31:0] result;
  logic        undef;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  crc32_acc_unit u0 (.clk(clk), .rst_n(rst_n), .insn(insn), .feat_en(feat_en),
    .acc_in(acc_in), .data_in(data_in), .result(result), .undef(undef));

  function automatic logic [31:0] mk(input logic sf, input logic c, input logic [1:0] sz,
                                     input logic [4:0] rm, input logic [4:0] rn, input logic [4:0] rd);
    return {sf, 10'b0011010110, rm, 3'b010, c, sz, rn, rd};
  endfunction

  // long division on the bit-reversed dividend, most significant bit first
  function automatic logic [31:0] ref_crc(input logic [31:0] a, input logic [63:0] d,
                                          input int size, input logic c);
    logic [95:0] dv;
    logic [32:0] g;
    logic [31:0] r;
    int len;
    len = 32 + size;
    g = {1'b1, c ? 32'h1EDC6F41 : 32'h04C11DB7};
    dv = '0;
    for (int i = 0; i < 32; i++) dv[len-1-i] = a[i];
    for (int j = 0; j < size; j++) dv[len-1-j] = dv[len-1-j] ^ d[j];
    for (int k = len - 1; k >= 32; k--)
      if (dv[k]) dv[k-:33] = dv[k-:33] ^ g;
    for (int i = 0; i < 32; i++) r[i] = dv[31-i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [31:0] a, input logic [63:0] d);
    insn = i; acc_in = a; data_in = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    insn = mk(1, 0, 3, 1, 2, 3); acc_in = 32'hFFFFFFFF; data_in = '1; feat_en = 0;
    repeat (3) @(negedge clk);
    check("R1 result", result, 0);
    check("R1 undef", {31'b0, undef}, 0);
    feat_en = 1;
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_string(input logic c, input logic [31:0] exp, input string req);
    logic [31:0] a;
    logic [7:0] s [9];
    for (int i = 0; i < 9; i++) s[i] = 8'h31 + 8'(i);
    a = 32'hFFFFFFFF;
    for (int i = 0; i < 9; i++) begin
      apply(mk(0, c, 0, 4, 5, 6), a, {56'h0, s[i]});
      a = result;
    end
    check({req, " bytes"}, a ^ 32'hFFFFFFFF, exp);
    apply(mk(1, c, 3, 4, 5, 6), 32'hFFFFFFFF,
          {s[7], s[6], s[5], s[4], s[3], s[2], s[1], s[0]});
    a = result;
    apply(mk(0, c, 0, 4, 5, 6), a, {56'h0, s[8]});
    check({req, " R2 64+8"}, result ^ 32'hFFFFFFFF, exp);
    apply(mk(0, c, 1, 4, 5, 6), 32'hFFFFFFFF, {48'h0, s[1], s[0]});
    a = result;
    apply(mk(0, c, 2, 4, 5, 6), a, {32'h0, s[5], s[4], s[3], s[2]});
    a = result;
    apply(mk(0, c, 1, 4, 5, 6), a, {48'h0, s[7], s[6]});
    a = result;
    apply(mk(0, c, 0, 4, 5, 6), a, {56'h0, s[8]});
    check({req, " R2 16/32"}, result ^ 32'hFFFFFFFF, exp);
  endtask

  task automatic t_widths;
    logic [31:0] a;
    logic [63:0] d;
    a = 32'h1234ABCD;
    d = 64'hDEADBEEF_0BADF00D;
    for (int c = 0; c < 2; c++)
      for (int sz = 0; sz < 4; sz++) begin
        apply(mk(sz == 3, c[0], sz[1:0], 0, 0, 0), a, d);
        check(c ? "R4 width" : "R3 width", result, ref_crc(a, d, 8 << sz, c[0]));
        a = a * 32'h9E3779B1 + 32'h7F4A7C15;
        d = {d[31:0] ^ 32'hA5A5_5A5A, d[63:32] + 32'h1357};
      end
  endtask

  task automatic t_upper_ignored;
    logic [31:0] r0;
    apply(mk(0, 0, 0, 0, 0, 0), 32'hCAFEF00D, 64'h0000_0000_0000_005A);
    r0 = result;
    apply(mk(0, 0, 0, 0, 0, 0), 32'hCAFEF00D, 64'hFFFF_FFFF_FFFF_FF5A);
    check("R2 upper bits 8", result, r0);
    apply(mk(0, 1, 2, 0, 0, 0), 32'h0, 64'h0000_0000_8765_4321);
    r0 = result;
    apply(mk(0, 1, 2, 0, 0, 0), 32'h0, 64'h1234_5678_8765_4321);
    check("R2 upper bits 32", result, r0);
  endtask

  task automatic t_legality;
    for (int sz = 0; sz < 3; sz++) begin
      apply(mk(1, 0, sz[1:0], 0, 0, 0), 32'hFFFFFFFF, '1);
      check("R5 sf1 undef", {31'b0, undef}, 1);
      check("R8 zero", result, 0);
    end
    apply(mk(0, 1, 3, 0, 0, 0), 32'hFFFFFFFF, '1);
    check("R5 sf0 undef", {31'b0, undef}, 1);
    check("R8 zero", result, 0);
    apply(mk(1, 1, 3, 0, 0, 0), 32'hFFFFFFFF, '1);
    check("R5 legal", {31'b0, undef}, 0);
  endtask

  task automatic t_feature;
    feat_en = 0;
    apply(mk(0, 0, 0, 0, 0, 0), 32'hFFFFFFFF, 64'h31);
    check("R6 undef", {31'b0, undef}, 1);
    check("R6 R8 zero", result, 0);
    feat_en = 1;
    apply(mk(0, 0, 0, 0, 0, 0), 32'hFFFFFFFF, 64'h31);
    check("R6 enabled", {31'b0, undef}, 0);
  endtask

  task automatic t_opcode;
    logic [31:0] good;
    good = mk(0, 0, 2, 0, 0, 0);
    for (int b = 13; b <= 30; b++) begin
      if (b >= 16 && b <= 20) continue;
      apply(good ^ (32'h1 << b), 32'h55AA55AA, 64'h1);
      check($sformatf("R7 bit %0d", b), {31'b0, undef}, 1);
    end
    check("R8 zero after bad opcode", result, 0);
  endtask

  task automatic t_fields_ignored;
    logic [31:0] r0;
    apply(mk(0, 1, 1, 0, 0, 0), 32'h0F0F0F0F, 64'hBEEF);
    r0 = result;
    apply(mk(0, 1, 1, 31, 17, 9), 32'h0F0F0F0F, 64'hBEEF);
    check("R10 fields", result, r0);
    check("R10 undef", {31'b0, undef}, 0);
  endtask

  task automatic t_latency;
    insn = mk(0, 0, 0, 0, 0, 0); acc_in = 32'hFFFFFFFF; data_in = 64'h31;
    @(posedge clk); @(negedge clk);
    acc_in = 32'h0;
    #1;
    check("R9 held until edge", result, ref_crc(32'hFFFFFFFF, 64'h31, 8, 0));
    @(posedge clk); @(negedge clk);
    check("R9 next edge", result, ref_crc(32'h0, 64'h31, 8, 0));
  endtask

  initial begin
    t_reset();
    t_string(0, 32'hCBF43926, "R3");
    t_string(1, 32'hE3069283, "R4");
    t_widths();
    t_upper_ignored();
    t_legality();
    t_feature();
    t_opcode();
    t_fields_ignored();
    t_latency();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule